// File: doc/BRIEF.md
# Power-Good Failure Sticky Monitor

This block watches the platform power-good input and records, in a single sticky status bit, any loss of power-good while the system is running or in light sleep. It runs on the real-time clock. The asynchronous power-good level first passes through a two-flop synchronizer. The synchronized low is then qualified by the current system-state code. A qualified low sets the status bit, and the bit keeps its value after power-good comes back.

Firmware reads the bit and clears it by writing one. A zero write does nothing. The bit also clears when the system-state code reports mechanical-off. Because power-good is only sampled on real-time clock edges, a low pulse that begins and ends between two edges is not recorded. Regulator sequencing and reset generation are handled elsewhere. Only power-good is monitored, because in a real failure it drops before the regulator's own good signal.

Top module: `pgf_monitor`

## Requirements
- R1: While `rstN` is low and after reset is released, `failSts` reads 0 until a qualified failure occurs.
- R2: If `pwrGood` falls before rising edge k and stays low, with `sysState` = 0 (working), `failSts` is still 0 after edge k+1 and is 1 after edge k+2.
- R3: With `sysState` = 1 (light sleep), a sustained low on `pwrGood` also sets `failSts`, with the same latency as R2.
- R4: Only state codes 0 and 1 qualify a failure. A low on `pwrGood` while `sysState` is 3, 4, 5 or the unused codes 2 and 6 leaves `failSts` at 0.
- R5: A cycle with `wrEn`=1 and `wrData`=1 clears `failSts` at that edge. A write with `wrData`=0 leaves `failSts` unchanged.
- R6: `sysState` = 7 (mechanical-off) clears `failSts` at the next rising edge.
- R7: When a qualified synchronized low and a write-one clear fall on the same edge, the set wins and `failSts` stays 1.
- R8: `failSts` stays 1 after `pwrGood` returns high, until a clear from R5 or R6.
- R9: A low pulse on `pwrGood` that starts and ends between two consecutive rising edges is not recorded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rtcClk | input | 1 | Real-time clock. All sampling occurs on its rising edge. |
| rstN | input | 1 | Active-low asynchronous reset |
| pwrGood | input | 1 | Platform power-good level. Asynchronous to `rtcClk`. |
| sysState | input | 3 | System state: 0 working, 1 light sleep, 3/4/5 deeper sleeps, 7 mechanical-off |
| wrEn | input | 1 | Write strobe for the status bit |
| wrData | input | 1 | Write data. A 1 clears the bit. |
| failSts | output | 1 | Sticky power-good failure status |

## Verification
Sustained lows in each state code separate a correct state qualification from one that accepts deeper sleeps or undefined codes. Lows that start between edges and are released before the next edge test the sampling rule of R9. A write-one placed on the exact edge where a failure is set checks the set-over-clear priority, and zero writes show that a clear needs a one. A long random mix of slowly varying power-good, state codes and writes is compared every cycle against a bench model of the three-edge latency, which shows whether the synchronizer has too few or too many flops.

// File: rtl/pgf_pkg.sv
package pgf_pkg;
  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_WORK  = 3'd0,
    ST_LIGHT = 3'd1,
    ST_RSV2  = 3'd2,
    ST_SUSP  = 3'd3,
    ST_HIBR  = 3'd4,
    ST_SOFT  = 3'd5,
    ST_RSV6  = 3'd6,
    ST_MOFF  = 3'd7
  } sysState_e;

  typedef struct packed {
    logic setReq;
    logic swClr;
    logic offClr;
  } pgStrobe_t;
endpackage

// File: rtl/pgf_ctrl.sv
module pgf_ctrl
  import pgf_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               rtcClk,
  input  logic               rstN,
  input  logic               pwrGood,
  input  logic [STATE_W-1:0] sysState,
  input  logic               wrEn,
  input  logic               wrData,
  output pgStrobe_t          strobes
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] pgSync;
  logic                   activeState;

  // synchronizer chain, reset to "power good" so no false event
  always_ff @(posedge rtcClk or negedge rstN) begin
    if (!rstN) pgSync <= '1;
    else       pgSync <= {pgSync[SYNC_STAGES-2:0], pwrGood};
  end

  always_comb begin
    activeState    = (sysState == ST_WORK) || (sysState == ST_LIGHT);
    strobes.setReq = !pgSync[LAST] && activeState;
    strobes.swClr  = wrEn && wrData;
    strobes.offClr = (sysState == ST_MOFF);
  end
endmodule

// File: rtl/pgf_datapath.sv
module pgf_datapath
  import pgf_pkg::*;
(
  input  logic      rtcClk,
  input  logic      rstN,
  input  pgStrobe_t strobes,
  output logic      failSts
);
  always_ff @(posedge rtcClk or negedge rstN) begin
    if (!rstN)                                 failSts <= 1'b0;
    else if (strobes.setReq)                   failSts <= 1'b1;
    else if (strobes.swClr || strobes.offClr)  failSts <= 1'b0;
  end

  // R7
  set_wins_chk: assert property (@(posedge rtcClk) disable iff (!rstN)
    (strobes.setReq && strobes.swClr) |=> failSts);

  // R5
  sw_clear_chk: assert property (@(posedge rtcClk) disable iff (!rstN)
    (strobes.swClr && !strobes.setReq) |=> !failSts);

  // R6
  off_clear_chk: assert property (@(posedge rtcClk) disable iff (!rstN)
    strobes.offClr |=> !failSts);

  // R8
  hold_chk: assert property (@(posedge rtcClk) disable iff (!rstN)
    (failSts && !strobes.swClr && !strobes.offClr) |=> failSts);
endmodule

// File: rtl/pgf_monitor.sv
module pgf_monitor
  import pgf_pkg::*;
(
  input  logic       rtcClk,
  input  logic       rstN,
  input  logic       pwrGood,
  input  logic [2:0] sysState,
  input  logic       wrEn,
  input  logic       wrData,
  output logic       failSts
);
  pgStrobe_t strobes;

  pgf_ctrl #(.SYNC_STAGES(2)) ctrlInst (
    .rtcClk  (rtcClk),
    .rstN    (rstN),
    .pwrGood (pwrGood),
    .sysState(sysState),
    .wrEn    (wrEn),
    .wrData  (wrData),
    .strobes (strobes)
  );

  pgf_datapath dpInst (
    .rtcClk (rtcClk),
    .rstN   (rstN),
    .strobes(strobes),
    .failSts(failSts)
  );

  // R4
  sleep_gate_chk: assert property (@(posedge rtcClk) disable iff (!rstN)
    $rose(failSts) |-> ($past(sysState) == 3'd0 || $past(sysState) == 3'd1));

  // R1
  reset_val_chk: assert property (@(posedge rtcClk)
    !rstN |-> !failSts);
endmodule

// File: tb/pgf_monitor_test.sv
module pgf_monitor_test;
  logic       rtcClk = 1'b0;
  logic       rstN = 1'b0;
  logic       pwrGood = 1'b1;
  logic [2:0] sysState = 3'd0;
  logic       wrEn = 1'b0;
  logic       wrData = 1'b0;
  logic       failSts;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  // bench model state
  logic m1 = 1'b1, m2 = 1'b1, mSts = 1'b0;

  always #5 rtcClk = ~rtcClk;

  pgf_monitor uut (
    .rtcClk(rtcClk), .rstN(rstN), .pwrGood(pwrGood), .sysState(sysState),
    .wrEn(wrEn), .wrData(wrData), .failSts(failSts)
  );

  function automatic logic nextSts(logic cur, logic seenPg, logic [2:0] st,
                                   logic we, logic wd);
    if (!seenPg && (st == 3'd0 || st == 3'd1)) return 1'b1;
    if ((we && wd) || st == 3'd7) return 1'b0;
    return cur;
  endfunction

  always @(posedge rtcClk or negedge rstN) begin
    if (!rstN) begin
      m1 <= 1'b1; m2 <= 1'b1; mSts <= 1'b0;
    end else begin
      mSts <= nextSts(mSts, m2, sysState, wrEn, wrData);
      m2 <= m1;
      m1 <= pwrGood;
    end
  end

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: failSts=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge rtcClk);
    @(negedge rtcClk);
  endtask

  task automatic clearAll();
    pwrGood = 1'b1; sysState = 3'd7; wrEn = 1'b0; wrData = 1'b0;
    step(3);
    sysState = 3'd0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    step(2);
    check("R1 in reset", failSts, 1'b0);
    rstN = 1'b1;
    step(3);
    check("R1 after reset", failSts, 1'b0);

    // R2 latency in working state
    pwrGood = 1'b0;
    step(2);
    check("R2 not yet after k+1", failSts, 1'b0);
    step(1);
    check("R2 set after k+2", failSts, 1'b1);
    // R8 sticky after recovery
    pwrGood = 1'b1;
    step(4);
    check("R8 held high", failSts, 1'b1);
    // R5 zero write has no effect
    wrEn = 1'b1; wrData = 1'b0;
    step(1);
    wrEn = 1'b0;
    check("R5 zero write", failSts, 1'b1);
    wrEn = 1'b1; wrData = 1'b1;
    step(1);
    wrEn = 1'b0; wrData = 1'b0;
    check("R5 one write clears", failSts, 1'b0);

    // R3 light sleep
    sysState = 3'd1; pwrGood = 1'b0;
    step(3);
    check("R3 light sleep set", failSts, 1'b1);
    pwrGood = 1'b1;
    step(3);
    // R6 mechanical-off clears
    sysState = 3'd7;
    step(1);
    check("R6 off clears", failSts, 1'b0);

    // R4 non-qualifying states
    for (int i = 2; i <= 6; i++) begin
      sysState = 3'(i); pwrGood = 1'b0;
      step(5);
      check($sformatf("R4 state %0d ignored", i), failSts, 1'b0);
      pwrGood = 1'b1;
      step(3);
    end

    // R7 set beats clear on the same edge
    sysState = 3'd0; pwrGood = 1'b0;
    step(2);
    wrEn = 1'b1; wrData = 1'b1;
    step(1);
    check("R7 set beats clear", failSts, 1'b1);
    step(1);
    wrEn = 1'b0; wrData = 1'b0;
    check("R7 set persists while low", failSts, 1'b1);
    clearAll();

    // R9 pulse between edges
    #1 pwrGood = 1'b0;
    #2 pwrGood = 1'b1;
    step(4);
    check("R9 short pulse missed", failSts, 1'b0);

    // random phase compared against bench model
    for (int c = 0; c < 3000; c++) begin
      check("R2/R3/R4/R5/R6/R7/R8 random", failSts, mSts);
      if ($urandom_range(0, 9) == 0) pwrGood = ~pwrGood;
      if ($urandom_range(0, 7) == 0) sysState = 3'($urandom_range(0, 7));
      wrEn   = ($urandom_range(0, 5) == 0);
      wrData = 1'($urandom);
      step(1);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule